// File: doc/BRIEF.md
# Health Page Temperature Monitor

This block keeps the over-temperature state and the time-varying part of a storage controller's health log page. It holds the latest composite temperature (in kelvin) taken from a sensor strobe and a software-written over-temperature threshold. From these it presents the critical-warning byte and the two temperature bytes of the page. A millisecond tick drives a chain of prescalers that turns elapsed time since reset into whole power-on hours.

Threshold writes arrive on a valid/ready port. When a write is accepted and the new threshold is at or below the temperature, the block emits a one-cycle health event request. The request carries the event class, the temperature-threshold info code and the health page identifier. Page fields not produced here read as zero and are assembled elsewhere.

Top module: `hm_health_temp_mon`

## Requirements
- R1: After reset the temperature is 0x0143, the threshold reads 0x014D, critical warning is 0x00, power-on hours are 0 and no event is raised.
- R2: A threshold write is accepted on any cycle where `thr_wr_valid` is high, because `thr_wr_ready` is always 1. `thr_rd_data` shows the written value from the next cycle on and holds it until the next write.
- R3: A cycle with `temp_valid` high loads `temp_data`. `temp_lo` carries bits 7:0 of the held temperature and `temp_hi` carries bits 15:8.
- R4: Bit 1 of `crit_warn` is 1 exactly when the held threshold is less than or equal to the held temperature. It is re-evaluated whenever either value changes.
- R5: An accepted threshold write whose value is less than or equal to the temperature raises `evt_valid` in the following cycle. A write above the temperature raises nothing, and no cycle without a write raises anything.
- R6: `evt_valid` lasts one cycle per qualifying write. While it is high, `evt_type` is 1 (health class), `evt_info` is 0x01 (temperature threshold) and `evt_log_id` is 0x02 (health page). While it is low, all three are 0.
- R7: `poh_hours` equals the count of `ms_tick` cycles since reset, divided by MS_PER_SEC, then by SEC_PER_MIN, then by MIN_PER_HOUR, each with truncation. The new value is visible in the cycle after the tick that completes an hour.
- R8: `poh_hours` stops at its all-ones value and does not wrap.
- R9: When a threshold write and a temperature load share a cycle, the event decision uses the newly loaded temperature.
- R10: Bits 7:2 and bit 0 of `crit_warn` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_valid | input | 1 | Sensor update strobe |
| temp_data | input | 16 | New composite temperature in kelvin |
| thr_wr_valid | input | 1 | Threshold write request |
| thr_wr_ready | output | 1 | Threshold write accept, always 1 |
| thr_wr_data | input | 16 | Threshold value to store |
| thr_rd_data | output | 16 | Stored threshold |
| ms_tick | input | 1 | One pulse per elapsed millisecond |
| evt_valid | output | 1 | One-cycle health event request |
| evt_type | output | 3 | Event class |
| evt_info | output | 8 | Event info code |
| evt_log_id | output | 8 | Page to read for the event |
| crit_warn | output | 8 | Critical-warning byte |
| temp_lo | output | 8 | Temperature low byte |
| temp_hi | output | 8 | Temperature high byte |
| poh_hours | output | HOURS_W | Whole power-on hours |

## Verification
The threshold compare is tried with writes above, equal to and below the held temperature. This separates a correct `<=` from `<` or `>=` in both the event path and the warning bit. Temperature loads that cross the threshold in each direction with no write show that the warning follows the temperature while no event is raised. A write and a load in the same cycle show whether the event decision sees the new or the old temperature. Back-to-back writes show that each write gets its own pulse. The bench uses small prescaler moduli and a narrow hours counter, driven by both continuous and gapped ticks, to exercise every prescaler carry, the hour step and saturation.

// File: rtl/hm_pkg.sv
package hm_pkg;
  localparam int          TEMP_W        = 16;
  localparam logic [15:0] RESET_TEMP    = 16'h0143;
  localparam logic [15:0] RESET_THR     = 16'h014D;
  localparam logic [2:0]  EVT_CLASS_HLT = 3'd1;
  localparam logic [7:0]  EVT_INFO_THR  = 8'h01;
  localparam logic [7:0]  PAGE_ID_HLT   = 8'h02;
  localparam int          CW_TEMP_BIT   = 1;
endpackage

// File: rtl/hm_modcount.sv
module hm_modcount #(
  parameter int MOD = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  output logic carry
);
  localparam int W = (MOD > 1) ? $clog2(MOD) : 1;

  generate
    if (MOD <= 1) begin : g_pass
      assign carry = inc;
    end else begin : g_cnt
      logic [W-1:0] cnt_q;
      localparam logic [W-1:0] LAST = W'(MOD - 1);
      assign carry = inc && (cnt_q == LAST);
      always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (carry)    cnt_q <= '0;
        else if (inc)      cnt_q <= cnt_q + W'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/hm_uptime.sv
module hm_uptime #(
  parameter int MS_PER_SEC   = 1000,
  parameter int SEC_PER_MIN  = 60,
  parameter int MIN_PER_HOUR = 60,
  parameter int HOURS_W      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ms_tick,
  output logic [HOURS_W-1:0] hours
);
  localparam int NSTAGE = 3;
  localparam int MODS [NSTAGE] = '{MS_PER_SEC, SEC_PER_MIN, MIN_PER_HOUR};
  localparam logic [HOURS_W-1:0] HMAX = '1;

  logic [NSTAGE:0] carry;
  assign carry[0] = ms_tick;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    hm_modcount #(.MOD(MODS[s])) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (carry[s]),
      .carry (carry[s+1])
    );
  end

  logic [HOURS_W-1:0] hours_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                              hours_q <= '0;
    else if (carry[NSTAGE] && hours_q != HMAX) hours_q <= hours_q + HOURS_W'(1);
  end
  assign hours = hours_q;
endmodule

// File: rtl/hm_limit_reg.sv
module hm_limit_reg
  import hm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              temp_valid,
  input  logic [TEMP_W-1:0] temp_data,
  input  logic              thr_wr_valid,
  input  logic [TEMP_W-1:0] thr_wr_data,
  output logic [TEMP_W-1:0] temp_q,
  output logic [TEMP_W-1:0] thr_q,
  output logic              evt_q
);
  logic [TEMP_W-1:0] temp_nx;
  assign temp_nx = temp_valid ? temp_data : temp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temp_q <= RESET_TEMP;
      thr_q  <= RESET_THR;
      evt_q  <= 1'b0;
    end else begin
      temp_q <= temp_nx;
      if (thr_wr_valid) thr_q <= thr_wr_data;
      evt_q  <= thr_wr_valid && (thr_wr_data <= temp_nx);
    end
  end
endmodule

// File: rtl/hm_page_fmt.sv
module hm_page_fmt
  import hm_pkg::*;
(
  input  logic [TEMP_W-1:0] temp_q,
  input  logic [TEMP_W-1:0] thr_q,
  input  logic              evt_q,
  output logic [7:0]        crit_warn,
  output logic [7:0]        temp_lo,
  output logic [7:0]        temp_hi,
  output logic [2:0]        evt_type,
  output logic [7:0]        evt_info,
  output logic [7:0]        evt_log_id
);
  always_comb begin
    crit_warn              = 8'h00;
    crit_warn[CW_TEMP_BIT] = (thr_q <= temp_q);
    temp_lo                = temp_q[7:0];
    temp_hi                = temp_q[15:8];
    evt_type               = evt_q ? EVT_CLASS_HLT : 3'd0;
    evt_info               = evt_q ? EVT_INFO_THR  : 8'h00;
    evt_log_id             = evt_q ? PAGE_ID_HLT   : 8'h00;
  end
endmodule

// File: rtl/hm_health_temp_mon.sv
module hm_health_temp_mon
  import hm_pkg::*;
#(
  parameter int MS_PER_SEC   = 1000,
  parameter int SEC_PER_MIN  = 60,
  parameter int MIN_PER_HOUR = 60,
  parameter int HOURS_W      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               temp_valid,
  input  logic [15:0]        temp_data,
  input  logic               thr_wr_valid,
  output logic               thr_wr_ready,
  input  logic [15:0]        thr_wr_data,
  output logic [15:0]        thr_rd_data,
  input  logic               ms_tick,
  output logic               evt_valid,
  output logic [2:0]         evt_type,
  output logic [7:0]         evt_info,
  output logic [7:0]         evt_log_id,
  output logic [7:0]         crit_warn,
  output logic [7:0]         temp_lo,
  output logic [7:0]         temp_hi,
  output logic [HOURS_W-1:0] poh_hours
);
  logic [TEMP_W-1:0] temp_q, thr_q;
  logic              evt_q;

  assign thr_wr_ready = 1'b1;

  hm_limit_reg u_limit (
    .clk          (clk),
    .rst_n        (rst_n),
    .temp_valid   (temp_valid),
    .temp_data    (temp_data),
    .thr_wr_valid (thr_wr_valid),
    .thr_wr_data  (thr_wr_data),
    .temp_q       (temp_q),
    .thr_q        (thr_q),
    .evt_q        (evt_q)
  );

  hm_page_fmt u_fmt (
    .temp_q     (temp_q),
    .thr_q      (thr_q),
    .evt_q      (evt_q),
    .crit_warn  (crit_warn),
    .temp_lo    (temp_lo),
    .temp_hi    (temp_hi),
    .evt_type   (evt_type),
    .evt_info   (evt_info),
    .evt_log_id (evt_log_id)
  );

  hm_uptime #(
    .MS_PER_SEC   (MS_PER_SEC),
    .SEC_PER_MIN  (SEC_PER_MIN),
    .MIN_PER_HOUR (MIN_PER_HOUR),
    .HOURS_W      (HOURS_W)
  ) u_uptime (
    .clk     (clk),
    .rst_n   (rst_n),
    .ms_tick (ms_tick),
    .hours   (poh_hours)
  );

  assign thr_rd_data = thr_q;
  assign evt_valid   = evt_q;
endmodule

// File: rtl/hm_health_chk.sv
module hm_health_chk #(
  parameter int HOURS_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               temp_valid,
  input logic [15:0]        temp_data,
  input logic               thr_wr_valid,
  input logic [15:0]        thr_wr_data,
  input logic [15:0]        thr_rd_data,
  input logic               evt_valid,
  input logic [2:0]         evt_type,
  input logic [7:0]         evt_info,
  input logic [7:0]         evt_log_id,
  input logic [7:0]         crit_warn,
  input logic [7:0]         temp_lo,
  input logic [7:0]         temp_hi,
  input logic [HOURS_W-1:0] poh_hours
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_crit_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    crit_warn[1] == (thr_rd_data <= {temp_hi, temp_lo}));

  assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (crit_warn & 8'hFD) == 8'h00);

  assert_evt_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && evt_valid) |-> $past(thr_wr_valid));

  assert_evt_fields_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_type == 3'd1 && evt_info == 8'h01 && evt_log_id == 8'h02));

  assert_thr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(thr_wr_valid)) |-> $stable(thr_rd_data));

  assert_temp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(temp_valid)) |-> ($stable(temp_lo) && $stable(temp_hi)));

  assert_hours_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && poh_hours != $past(poh_hours)) |-> poh_hours == $past(poh_hours) + 1'b1);
endmodule

bind hm_health_temp_mon hm_health_chk #(.HOURS_W(HOURS_W)) u_chk (.*);

// File: tb/tb_hm_health_temp_mon.sv
module tb_hm_health_temp_mon;
  localparam int MSPS = 4, SPM = 3, MPH = 2, HW = 4;
  localparam int HMAX = (1 << HW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic temp_valid = 1'b0, thr_wr_valid = 1'b0, ms_tick = 1'b0;
  logic [15:0] temp_data = '0, thr_wr_data = '0;
  logic thr_wr_ready, evt_valid;
  logic [15:0] thr_rd_data;
  logic [2:0] evt_type;
  logic [7:0] evt_info, evt_log_id, crit_warn, temp_lo, temp_hi;
  logic [HW-1:0] poh_hours;

  always #2.5 clk = ~clk;

  hm_health_temp_mon #(.MS_PER_SEC(MSPS), .SEC_PER_MIN(SPM), .MIN_PER_HOUR(MPH),
                       .HOURS_W(HW)) dut (.*);

  int checks = 0, failures = 0;
  int m_temp, m_thr, m_ms, m_hours;
  bit m_evt;
  bit done = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      m_temp = 'h143; m_thr = 'h14D; m_evt = 0; m_ms = 0; m_hours = 0;
    end else begin
      if (temp_valid) m_temp = temp_data;
      m_evt = thr_wr_valid && (thr_wr_data <= m_temp);
      if (thr_wr_valid) m_thr = thr_wr_data;
      if (ms_tick) m_ms++;
      m_hours = m_ms / MSPS / SPM / MPH;
      if (m_hours > HMAX) m_hours = HMAX;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 ready", thr_wr_ready, 1);
      chk("R2 threshold", thr_rd_data, m_thr);
      chk("R3 temp_lo", temp_lo, m_temp & 'hFF);
      chk("R3 temp_hi", temp_hi, (m_temp >> 8) & 'hFF);
      chk("R4 R10 crit_warn", crit_warn, (m_thr <= m_temp) ? 'h02 : 'h00);
      chk("R5 R9 evt_valid", evt_valid, m_evt);
      chk("R6 evt_type", evt_type, m_evt ? 1 : 0);
      chk("R6 evt_info", evt_info, m_evt ? 'h01 : 0);
      chk("R6 evt_log_id", evt_log_id, m_evt ? 'h02 : 0);
      chk("R7 R8 poh_hours", poh_hours, m_hours);
    end
  end

  task automatic step(input bit tv, input int td, input bit wv, input int wd, input bit tk);
    temp_valid = tv; temp_data = 16'(td);
    thr_wr_valid = wv; thr_wr_data = 16'(wd); ms_tick = tk;
    @(negedge clk);
    temp_valid = 0; thr_wr_valid = 0; ms_tick = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(5 * 50000);
    done = 1;
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 temp", {temp_hi, temp_lo}, 'h143);
    chk("R1 thr", thr_rd_data, 'h14D);
    chk("R1 crit", crit_warn, 0);
    chk("R1 hours", poh_hours, 0);
    chk("R1 evt", evt_valid, 0);
    step(0, 0, 1, 'h200, 0);   // above: no event (R5)
    step(0, 0, 0, 0, 0);
    step(0, 0, 1, 'h143, 0);   // equal: event (R5)
    step(0, 0, 0, 0, 0);
    step(0, 0, 1, 'h100, 0);   // below: event
    step(0, 0, 0, 0, 0);
    step(1, 'h0F0, 0, 0, 0);   // temp below thr: crit clears (R4)
    step(1, 'h100, 0, 0, 0);   // equal: crit sets, no event
    step(1, 'h0FF, 0, 0, 0);
    step(1, 'h300, 1, 'h2FF, 0); // R9 same cycle: new temp decides
    step(1, 'h100, 1, 'h2FF, 0); // R9 new temp lower: no event
    step(0, 0, 1, 'h0FE, 0);   // back-to-back writes (R6)
    step(0, 0, 1, 'h0FD, 0);
    step(0, 0, 1, 'h400, 0);
    step(0, 0, 0, 0, 0);
    step(1, 'hABCD, 0, 0, 0);  // R3 byte order
    // R7 gapped ticks
    for (int i = 0; i < 60; i++) step(0, 0, 0, 0, (i % 3) != 0);
    // R7 R8 continuous ticks up to saturation
    for (int i = 0; i < 420; i++) step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    chk("R8 saturated hours", poh_hours, HMAX);
    done = 1;
    summary();
  end
endmodule